// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block gathers eight interrupt sources of a packet-based serial bus master into one status register and raises a single interrupt line when any recorded source is also enabled in a mask register. Six of the sources are short event pulses from the transfer and FIFO logic. Each pulse is captured and held until software acknowledges it by writing a 1 to its bit. The two remaining sources are FIFO data requests. They are level signals, and the status bits mirror those levels.

Software uses a small register port to read either register and to write the mask or clear status bits. The per-packet completion source can be routed past its mask bit by a configuration input. This lets a controller that always wants completion notices get them without programming the mask. The interrupt output is a registered OR of the enabled pending bits.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the status register reads 0 (with both request inputs low), the mask register reads 0 and the interrupt output is low.
- R2: Status bit positions are fixed: 7 packet done, 6 all packets done, 5 transmit overflow, 4 receive underflow, 3 no acknowledge, 2 arbitration lost, 1 transmit data request, 0 receive data request. Event input `evt_i[k]` sets status bit k+2, and `req_i[k]` drives status bit k.
- R3: A captured event bit (bits 7..2) stays set, over any number of cycles, until it is cleared.
- R4: A write with `reg_sel_i`=0 clears each event bit whose write-data bit is 1. Event bits whose write-data bit is 0 keep their value.
- R5: When an event pulse and a clear of the same bit fall in the same cycle, the bit is set afterwards.
- R6: Status bits 1..0 equal `req_i` as sampled at the previous clock edge. A clear write to them has no lasting effect, and they read 0 one cycle after the request drops.
- R7: A write with `reg_sel_i`=1 loads the mask register. The read data is combinational: the status register when `reg_sel_i`=0, the mask register when `reg_sel_i`=1.
- R8: `irq_o` is registered. At each edge it takes the OR over all bits of the current status AND the effective mask, so it rises one cycle after the status bit that causes it.
- R9: While `pkt_bypass_i` is 1, status bit 7 counts as enabled whatever mask bit 7 holds. While it is 0, bit 7 needs its mask bit.
- R10: Masking does not affect capture. A source with a 0 mask bit is still recorded in status and still raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 6 | Event pulses, bit k sets status bit k+2 |
| req_i | input | 2 | Level data requests, bit 1 transmit, bit 0 receive |
| pkt_bypass_i | input | 1 | Packet-done reaches the interrupt regardless of its mask bit |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects status (write clears), 1 selects mask |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| irq_o | output | 1 | Registered interrupt output |

## Verification
The capture and gating path is driven with sparse random event pulses, random clear and mask writes, slowly changing request levels and a toggling bypass. A bench model predicts each cycle's read data and interrupt level. These random patterns expose wrong merges of clear and set, and off-by-one latency on the interrupt. Directed cases target the points that random traffic rarely reaches alone. They walk a single pulse across every event position to show the bit map. They clear and set the same bit together to show set priority. They hold a request while clearing it to show level tracking, and they hold packet-done with its mask bit at 0 while the bypass toggles to tell the bypass path from the masked path.

// File: rtl/irq_pkg.sv
package irq_pkg;

  localparam int unsigned IRQ_SRC_N   = 8;
  localparam int unsigned IRQ_LVL_N   = 2;
  localparam int unsigned POS_PKT     = 7;
  localparam int unsigned POS_ALL     = 6;
  localparam int unsigned POS_TX_OVF  = 5;
  localparam int unsigned POS_RX_UNF  = 4;
  localparam int unsigned POS_NOACK   = 3;
  localparam int unsigned POS_ARBLOST = 2;
  localparam int unsigned POS_TXREQ   = 1;
  localparam int unsigned POS_RXREQ   = 0;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_MASK   = 1'b1
  } reg_sel_e;

  // Sticky update: a new event outranks a clear in the same cycle.
  function automatic logic sticky_next(input logic cur, input logic clr, input logic set);
    return set | (cur & ~clr);
  endfunction

  // Effective enable of one source: mask bit, or forced on for the bypass source.
  function automatic logic enable_bit(input logic mask_bit, input logic is_bypass_src,
                                      input logic bypass_on);
    return mask_bit | (is_bypass_src & bypass_on);
  endfunction

endpackage

// File: rtl/irq_src_capture.sv
module irq_src_capture
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC = IRQ_SRC_N,
  parameter int unsigned N_LVL = IRQ_LVL_N
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_SRC-N_LVL-1:0] evt_i,
  input  logic [N_LVL-1:0]       req_i,
  input  logic [N_SRC-N_LVL-1:0] clr_i,
  output logic [N_SRC-1:0]       status_o
);
  localparam int unsigned N_EVT = N_SRC - N_LVL;

  logic [N_SRC-1:0] stat_q;
  logic [N_SRC-1:0] stat_d;

  generate
    for (genvar b = 0; b < N_SRC; b++) begin : g_bit
      if (b < N_LVL) begin : g_lvl
        assign stat_d[b] = req_i[b];
      end else begin : g_evt
        assign stat_d[b] = sticky_next(stat_q[b], clr_i[b-N_LVL], evt_i[b-N_LVL]);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign status_o = stat_q;

  logic [N_EVT-1:0] evt_hi;
  assign evt_hi = stat_q[N_SRC-1:N_LVL];

  // R3: an event bit not being cleared stays set
  assert_event_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    |(evt_hi & ~clr_i) |=> ((evt_hi & $past(evt_hi & ~clr_i)) == $past(evt_hi & ~clr_i)));

  // R4: a cleared bit without a new event reads 0
  assert_w1c_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    |(clr_i & ~evt_i) |=> ((evt_hi & $past(clr_i & ~evt_i)) == '0));

  // R5: a new event is set even when cleared in the same cycle
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    |evt_i |=> ((evt_hi & $past(evt_i)) == $past(evt_i)));

  // R6: level bits track the request one edge later
  assert_level_track_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (stat_q[N_LVL-1:0] == $past(req_i)));

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC   = IRQ_SRC_N,
  parameter int unsigned PKT_POS = POS_PKT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [N_SRC-1:0] wdata_i,
  input  logic             bypass_i,
  output logic [N_SRC-1:0] mask_o,
  output logic [N_SRC-1:0] eff_mask_o
);
  logic [N_SRC-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q <= '0;
    else if (wr_i) mask_q <= wdata_i;
  end

  generate
    for (genvar b = 0; b < N_SRC; b++) begin : g_en
      assign eff_mask_o[b] = enable_bit(mask_q[b], (b == PKT_POS), bypass_i);
    end
  endgenerate

  assign mask_o = mask_q;

  // R7: a mask write is read back unchanged
  assert_mask_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (mask_q == $past(wdata_i)));

  // R7: no write keeps the mask stable
  assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(mask_q));

endmodule

// File: rtl/irq_out_gate.sv
module irq_out_gate
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC = IRQ_SRC_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] status_i,
  input  logic [N_SRC-1:0] eff_mask_i,
  output logic             irq_o
);
  logic [N_SRC-1:0] pending_w;
  logic             irq_q;

  assign pending_w = status_i & eff_mask_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |pending_w;
  end

  assign irq_o = irq_q;

  // R8: an enabled pending bit raises the line one edge later
  assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|pending_w) |=> irq_q);

  // R8: no enabled pending bit drops the line one edge later
  assert_irq_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|pending_w) |=> !irq_q);

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC   = IRQ_SRC_N,
  parameter int unsigned N_LVL   = IRQ_LVL_N,
  parameter int unsigned PKT_POS = POS_PKT
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_SRC-N_LVL-1:0] evt_i,
  input  logic [N_LVL-1:0]       req_i,
  input  logic                   pkt_bypass_i,
  input  logic                   reg_we_i,
  input  logic                   reg_sel_i,
  input  logic [N_SRC-1:0]       reg_wdata_i,
  output logic [N_SRC-1:0]       reg_rdata_o,
  output logic                   irq_o
);
  localparam int unsigned N_EVT   = N_SRC - N_LVL;
  localparam int unsigned PKT_EVT = PKT_POS - N_LVL;

  reg_sel_e         sel_w;
  logic             status_wr_w;
  logic             mask_wr_w;
  logic [N_EVT-1:0] clr_w;
  logic [N_SRC-1:0] status_w;
  logic [N_SRC-1:0] mask_w;
  logic [N_SRC-1:0] eff_mask_w;

  assign sel_w       = reg_sel_e'(reg_sel_i);
  assign status_wr_w = reg_we_i && (sel_w == SEL_STATUS);
  assign mask_wr_w   = reg_we_i && (sel_w == SEL_MASK);
  assign clr_w       = status_wr_w ? reg_wdata_i[N_SRC-1:N_LVL] : '0;

  irq_src_capture #(.N_SRC(N_SRC), .N_LVL(N_LVL)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_i),
    .req_i    (req_i),
    .clr_i    (clr_w),
    .status_o (status_w)
  );

  irq_mask_reg #(.N_SRC(N_SRC), .PKT_POS(PKT_POS)) u_mask (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (mask_wr_w),
    .wdata_i    (reg_wdata_i),
    .bypass_i   (pkt_bypass_i),
    .mask_o     (mask_w),
    .eff_mask_o (eff_mask_w)
  );

  irq_out_gate #(.N_SRC(N_SRC)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .status_i   (status_w),
    .eff_mask_i (eff_mask_w),
    .irq_o      (irq_o)
  );

  always_comb begin
    case (sel_w)
      SEL_MASK: reg_rdata_o = mask_w;
      default:  reg_rdata_o = status_w;
    endcase
  end

  // R9: packet-done with bypass on raises the line whatever its mask bit
  assert_pkt_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_bypass_i && status_w[PKT_POS]) |=> irq_o);

  // R10: a packet-done pulse is captured even when its mask bit is 0
  assert_masked_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i[PKT_EVT] && !mask_w[PKT_POS]) |=> status_w[PKT_POS]);

endmodule

// File: tb/tb_irq_status_unit.sv
`timescale 1ns/1ps
module tb_irq_status_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] evt_i;
  logic [1:0] req_i;
  logic       pkt_bypass_i;
  logic       reg_we_i;
  logic       reg_sel_i;
  logic [7:0] reg_wdata_i;
  logic [7:0] reg_rdata_o;
  logic       irq_o;

  always #4 clk = ~clk;

  irq_status_unit dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .req_i(req_i),
    .pkt_bypass_i(pkt_bypass_i), .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  int         n_chk = 0;
  int         n_err = 0;
  bit         done  = 0;
  logic [7:0] m_st, m_mk;
  logic       m_irq;
  logic [7:0] obs_rd;
  logic       obs_irq;
  logic [1:0] req_r = 2'b00;
  logic       byp_r = 1'b0;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  // Bench model of the status register, written bit by bit from the requirements.
  function automatic logic [7:0] model_status(input logic [7:0] st, input logic [5:0] e,
                                              input logic [1:0] rq, input logic [7:0] clr);
    logic [7:0] ns;
    for (int i = 0; i < 8; i++) begin
      if (i < 2) ns[i] = rq[i];
      else if (e[i-2]) ns[i] = 1'b1;
      else if (clr[i]) ns[i] = 1'b0;
      else ns[i] = st[i];
    end
    return ns;
  endfunction

  function automatic logic model_irq(input logic [7:0] st, input logic [7:0] mk, input logic byp);
    logic [7:0] en;
    en = mk;
    if (byp) en[7] = 1'b1;
    return (st & en) != 8'h00;
  endfunction

  task automatic step(input logic [5:0] e, input logic we, input logic sel,
                      input logic [7:0] wd, input string tag);
    @(negedge clk);
    evt_i = e; reg_we_i = we; reg_sel_i = sel; reg_wdata_i = wd;
    req_i = req_r; pkt_bypass_i = byp_r;
    #1;
    obs_rd  = reg_rdata_o;
    obs_irq = irq_o;
    chk({tag, sel ? " R7 mask read" : " R3 status read"}, obs_rd, sel ? m_mk : m_st);
    chk({tag, " R8 irq"}, {7'b0, obs_irq}, {7'b0, m_irq});
    @(posedge clk);
    m_irq = model_irq(m_st, m_mk, byp_r);
    m_st  = model_status(m_st, e, req_r, (we && !sel) ? wd : 8'h00);
    if (we && sel) m_mk = wd;
  endtask

  task automatic idle(input logic sel, input string tag);
    step(6'h00, 1'b0, sel, 8'h00, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog R8: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; evt_i = '0; req_i = '0; pkt_bypass_i = 1'b0;
    reg_we_i = 1'b0; reg_sel_i = 1'b0; reg_wdata_i = '0;
    m_st = 8'h00; m_mk = 8'h00; m_irq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    idle(1'b0, "R1");
    chk("R1 status after reset", obs_rd, 8'h00);
    chk("R1 irq after reset", {7'b0, obs_irq}, 8'h00);
    idle(1'b1, "R1");
    chk("R1 mask after reset", obs_rd, 8'h00);

    // R2 bit map: walk one pulse over every event input
    for (int k = 0; k < 6; k++) begin
      step(6'h00, 1'b1, 1'b0, 8'hFF, "R2");
      step(6'h01 << k, 1'b0, 1'b0, 8'h00, "R2");
      idle(1'b0, "R2");
      chk("R2 event position", obs_rd, 8'h04 << k);
    end

    // R3 hold over several cycles
    step(6'h00, 1'b1, 1'b0, 8'hFF, "R3");
    step(6'h12, 1'b0, 1'b0, 8'h00, "R3");
    repeat (5) idle(1'b0, "R3");
    chk("R3 sticky hold", obs_rd, 8'h48);

    // R4 partial clear, then a zero write
    step(6'h3F, 1'b0, 1'b0, 8'h00, "R4");
    step(6'h00, 1'b1, 1'b0, 8'h0C, "R4");
    idle(1'b0, "R4");
    chk("R4 clear selected bits", obs_rd, 8'hF0);
    step(6'h00, 1'b1, 1'b0, 8'h00, "R4");
    idle(1'b0, "R4");
    chk("R4 zero write no effect", obs_rd, 8'hF0);

    // R5 set and clear together
    step(6'h00, 1'b1, 1'b0, 8'hFF, "R5");
    step(6'h01, 1'b1, 1'b0, 8'h04, "R5");
    idle(1'b0, "R5");
    chk("R5 set wins", obs_rd, 8'h04);

    // R6 level requests
    step(6'h00, 1'b1, 1'b0, 8'hFF, "R6");
    req_r = 2'b11;
    idle(1'b0, "R6");
    step(6'h00, 1'b1, 1'b0, 8'h03, "R6");
    chk("R6 level follows request", obs_rd, 8'h03);
    idle(1'b0, "R6");
    chk("R6 clear has no effect while held", obs_rd, 8'h03);
    req_r = 2'b00;
    idle(1'b0, "R6");
    idle(1'b0, "R6");
    chk("R6 level drops with request", obs_rd, 8'h00);

    // R7 mask write and read back
    step(6'h00, 1'b1, 1'b1, 8'hA5, "R7");
    idle(1'b1, "R7");
    chk("R7 mask readback", obs_rd, 8'hA5);

    // R8 latency through a mask bit
    step(6'h00, 1'b1, 1'b1, 8'h08, "R8");
    step(6'h02, 1'b0, 1'b0, 8'h00, "R8");
    idle(1'b0, "R8");
    chk("R8 irq not yet", {7'b0, obs_irq}, 8'h00);
    idle(1'b0, "R8");
    chk("R8 irq raised", {7'b0, obs_irq}, 8'h01);
    step(6'h00, 1'b1, 1'b0, 8'h08, "R8");
    idle(1'b0, "R8");
    idle(1'b0, "R8");
    chk("R8 irq dropped after clear", {7'b0, obs_irq}, 8'h00);

    // R9 bypass of packet-done
    step(6'h00, 1'b1, 1'b1, 8'h00, "R9");
    byp_r = 1'b1;
    step(6'h20, 1'b0, 1'b0, 8'h00, "R9");
    idle(1'b0, "R9");
    idle(1'b0, "R9");
    chk("R9 bypass raises irq", {7'b0, obs_irq}, 8'h01);
    byp_r = 1'b0;
    idle(1'b0, "R9");
    idle(1'b0, "R9");
    chk("R9 no bypass needs mask", {7'b0, obs_irq}, 8'h00);

    // R10 masked sources still captured
    step(6'h3F, 1'b0, 1'b0, 8'h00, "R10");
    idle(1'b0, "R10");
    idle(1'b0, "R10");
    chk("R10 masked captured", obs_rd, 8'hFC);
    chk("R10 masked no irq", {7'b0, obs_irq}, 8'h00);
    step(6'h00, 1'b1, 1'b0, 8'hFF, "R10");

    // Random traffic against the model
    for (int n = 0; n < 600; n++) begin
      logic [5:0] e;
      logic       we, sel;
      logic [7:0] wd;
      e   = ($urandom % 4 == 0) ? 6'($urandom) : 6'h00;
      we  = ($urandom % 4 == 0);
      sel = $urandom % 2;
      wd  = 8'($urandom);
      if ($urandom % 8 == 0) req_r = 2'($urandom);
      if ($urandom % 16 == 0) byp_r = ~byp_r;
      step(e, we, sel, wd, "rand");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule